// File: doc/BRIEF.md
# Dual-Clock Timer Register Bridge

An 8-bit timer/counter with a compare register and a control register, programmed by a host on the system clock. The counter itself runs either on the system clock or on a slow, unrelated oscillator clock, chosen by a select bit in a status register. Host writes first land in per-register holding registers. A toggle request/acknowledge handshake then carries each one into the timer domain, and a per-register busy flag stays set while its transfer is in flight.

When the running counter equals the compare value, the block raises a one-cycle interrupt in the system domain and can toggle a waveform output. A write to a register whose transfer is still pending is dropped and flagged with an error pulse. Changing the clock select clears the counter, compare and control registers. Counter reads return the live count, which in oscillator mode comes through a synchronized snapshot. Compare and control reads return the holding copy.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset, all four addresses read 0 and irq_o, wave_o and wr_err_o are low.
- R2: Address 3 is status. Bit 3 is the clock select (read/write, 0 = system clock, 1 = oscillator clock). Bit 2 is counter busy, bit 1 compare busy and bit 0 control busy. The three busy bits are read-only, so writing 1 to them has no effect.
- R3: With select 0, a write to address 0 (counter), 1 (compare) or 2 (control) takes effect at the next system clock edge, and the busy bits stay 0. Control bit 0 (run) makes the counter advance by one on every timer clock edge.
- R4: With select 1, an accepted write sets that register's busy bit by the next cycle. The bit clears once the value has been copied into the timer domain, and from then on the new value is in effect.
- R5: A write to a register whose busy bit is set is ignored (its stored value is unchanged), and wr_err_o pulses high for one cycle.
- R6: Reading address 1 or 2 returns the holding value, even while its transfer is pending. Reading address 0 returns the live counter value, through a synchronized snapshot when select is 1.
- R7: When the running counter equals the compare value, irq_o pulses for exactly one system cycle per match. If control bit 2 is set, wave_o toggles on the match.
- R8: If control bit 1 is set, the counter returns to 0 on a match, giving a match period of compare+1 counts. Otherwise it wraps from 255 to 0, giving a period of 256.
- R9: Any change of the select bit clears the counter, compare and control registers to 0 and clears every busy bit.
- R10: A counter write landing on the same timer edge as a match wins, and that match raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tclk_i | input | 1 | Oscillator clock for the counter when selected |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 2 | Register address: 0 counter, 1 compare, 2 control, 3 status |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Compare-match interrupt pulse, system domain |
| wave_o | output | 1 | Waveform output, toggled on match |
| wr_err_o | output | 1 | One-cycle pulse on a write rejected as busy |

## Verification
Two functions can fall on the same timer edge: a host counter write and a compare match on the old count. The bench runs the counter on the system clock, polls the live count at each falling edge, and issues a counter write in the half cycle where the count equals the compare value. It then judges that irq_o stays low, that the count shows the written value, and that no match follows while the count is away from the compare value. The other collision, a second write arriving while the first transfer is pending, is provoked right after an oscillator-mode write. It is judged by the error pulse and by the unchanged read-back value.

// File: rtl/atb_pkg.sv
`timescale 1ns/1ps
package atb_pkg;
  localparam int DW = 8;
  localparam int CW = 3;
  typedef enum logic [1:0] {
    A_CNT  = 2'd0,
    A_CMP  = 2'd1,
    A_CTL  = 2'd2,
    A_STAT = 2'd3
  } atb_addr_e;
  // control bits
  localparam int CTL_RUN = 0;
  localparam int CTL_CLR = 1;
  localparam int CTL_TGL = 2;
  // status bits (host visible)
  localparam int ST_SEL     = 3;
  localparam int ST_CNT_BSY = 2;
  localparam int ST_CMP_BSY = 1;
  localparam int ST_CTL_BSY = 0;
endpackage

// File: rtl/atb_xfer.sv
`timescale 1ns/1ps
module atb_xfer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic busy_o,
  input  logic tclk_i,
  input  logic trst_ni,
  output logic load_o
);
  logic req_q, ack_s1, ack_s2;
  logic req_t1, req_t2, ack_t;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else if (clr_i) begin
      req_q <= 1'b0; ack_s1 <= 1'b0; ack_s2 <= 1'b0;
    end else begin
      if (start_i) req_q <= ~req_q;
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge tclk_i or negedge trst_ni) begin
    if (!trst_ni) begin
      req_t1 <= 1'b0; req_t2 <= 1'b0; ack_t <= 1'b0;
    end else begin
      req_t1 <= req_q;
      req_t2 <= req_t1;
      ack_t  <= req_t2;
    end
  end

  assign load_o = req_t2 ^ ack_t;
  assign busy_o = req_q ^ ack_s2;

  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    start_i |=> busy_o);
endmodule

// File: rtl/atb_pulse_sync.sv
`timescale 1ns/1ps
module atb_pulse_sync (
  input  logic tclk_i,
  input  logic trst_ni,
  input  logic pulse_i,
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic pulse_o
);
  logic tg_q, s1_q, s2_q, s3_q;

  always_ff @(posedge tclk_i or negedge trst_ni) begin
    if (!trst_ni) tg_q <= 1'b0;
    else          tg_q <= tg_q ^ pulse_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else if (clr_i) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= tg_q; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  assign pulse_o = s2_q ^ s3_q;
endmodule

// File: rtl/atb_snap.sv
`timescale 1ns/1ps
module atb_snap #(
  parameter int DW = 8
) (
  input  logic          tclk_i,
  input  logic          trst_ni,
  input  logic [DW-1:0] d_i,
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [DW-1:0] q_o
);
  logic          req_q, a1_q, a2_q;
  logic          r1_t, r2_t, ack_t;
  logic [DW-1:0] hold_t;

  // timer side: capture only when a new request arrives, so hold_t is stable while sampled
  always_ff @(posedge tclk_i or negedge trst_ni) begin
    if (!trst_ni) begin
      r1_t <= 1'b0; r2_t <= 1'b0; ack_t <= 1'b0; hold_t <= '0;
    end else begin
      r1_t <= req_q;
      r2_t <= r1_t;
      if (r2_t != ack_t) begin
        hold_t <= d_i;
        ack_t  <= r2_t;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; a1_q <= 1'b0; a2_q <= 1'b0; q_o <= '0;
    end else if (clr_i) begin
      req_q <= 1'b0; a1_q <= 1'b0; a2_q <= 1'b0; q_o <= '0;
    end else begin
      a1_q <= ack_t;
      a2_q <= a1_q;
      if (a2_q == req_q) begin
        q_o   <= hold_t;
        req_q <= ~req_q;
      end
    end
  end
endmodule

// File: rtl/atb_core.sv
`timescale 1ns/1ps
module atb_core
  import atb_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_cnt_i,
  input  logic          ld_cmp_i,
  input  logic          ld_ctl_i,
  input  logic [DW-1:0] cnt_val_i,
  input  logic [DW-1:0] cmp_val_i,
  input  logic [CW-1:0] ctl_val_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o,
  output logic          wave_o
);
  logic [DW-1:0] cnt_q, cmp_q;
  logic [CW-1:0] ctl_q;
  logic          hit, match_q, wave_q;

  // a counter load in the same edge masks the match
  assign hit = ctl_q[CTL_RUN] && !ld_cnt_i && (cnt_q == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; cmp_q <= '0; ctl_q <= '0; match_q <= 1'b0; wave_q <= 1'b0;
    end else begin
      if (ld_cnt_i)                    cnt_q <= cnt_val_i;
      else if (hit && ctl_q[CTL_CLR])  cnt_q <= '0;
      else if (ctl_q[CTL_RUN])         cnt_q <= cnt_q + 1'b1;
      if (ld_cmp_i) cmp_q <= cmp_val_i;
      if (ld_ctl_i) ctl_q <= ctl_val_i;
      match_q <= hit;
      wave_q  <= wave_q ^ (hit && ctl_q[CTL_TGL]);
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign wave_o  = wave_q;

  // R7
  wave_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_q != $past(wave_q)) |-> match_q);
endmodule

// File: rtl/async_timer_bridge.sv
`timescale 1ns/1ps
module async_timer_bridge
  import atb_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tclk_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wave_o,
  output logic          wr_err_o
);
  localparam int NREG = 3;
  localparam int RW   = $clog2(RST_CYC + 1);

  logic          sel_q, wr_err_q, sel_chg, win_act, sclr, trst_n, t_clk;
  logic [RW-1:0] win_q;
  logic [DW-1:0] hold_q [NREG];
  logic [NREG-1:0] hit, busy_r, accept, start, xload, tload;
  logic [DW-1:0] cnt_t, cnt_s;
  logic          match_t, irq_s;

  assign t_clk   = sel_q ? tclk_i : clk_i;
  assign sel_chg = wr_en_i && (addr_i == A_STAT) && (wdata_i[ST_SEL] != sel_q);
  assign win_act = (win_q != '0);
  assign sclr    = sel_chg || win_act;
  assign trst_n  = rst_ni && !win_act;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i]    = wr_en_i && (addr_i == 2'(i));
    assign accept[i] = hit[i] && !busy_r[i];
    assign start[i]  = accept[i] && sel_q;
    assign tload[i]  = sel_q ? xload[i] : accept[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hold_q[i] <= '0;
      else if (sel_chg)   hold_q[i] <= '0;
      else if (accept[i]) hold_q[i] <= wdata_i;
    end

    atb_xfer u_xfer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (sclr),
      .start_i (start[i]),
      .busy_o  (busy_r[i]),
      .tclk_i  (t_clk),
      .trst_ni (trst_n),
      .load_o  (xload[i])
    );

    // R5
    hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[i] && busy_r[i] && !sel_chg) |=> $stable(hold_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0; win_q <= '0; wr_err_q <= 1'b0;
    end else begin
      if (sel_chg)      sel_q <= wdata_i[ST_SEL];
      if (sel_chg)      win_q <= RW'(RST_CYC);
      else if (win_act) win_q <= win_q - 1'b1;
      wr_err_q <= |(hit & busy_r);
    end
  end

  atb_core #(.DW(DW), .CW(CW)) u_core (
    .clk_i     (t_clk),
    .rst_ni    (trst_n),
    .ld_cnt_i  (tload[0]),
    .ld_cmp_i  (tload[1]),
    .ld_ctl_i  (tload[2]),
    .cnt_val_i (sel_q ? hold_q[0] : wdata_i),
    .cmp_val_i (sel_q ? hold_q[1] : wdata_i),
    .ctl_val_i (sel_q ? hold_q[2][CW-1:0] : wdata_i[CW-1:0]),
    .cnt_o     (cnt_t),
    .match_o   (match_t),
    .wave_o    (wave_o)
  );

  atb_snap #(.DW(DW)) u_snap (
    .tclk_i  (t_clk),
    .trst_ni (trst_n),
    .d_i     (cnt_t),
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sclr),
    .q_o     (cnt_s)
  );

  atb_pulse_sync u_irq (
    .tclk_i  (t_clk),
    .trst_ni (trst_n),
    .pulse_i (match_t),
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sclr),
    .pulse_o (irq_s)
  );

  assign irq_o    = sel_q ? irq_s : match_t;
  assign wr_err_o = wr_err_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CNT: rdata_o = sel_q ? cnt_s : cnt_t;
      A_CMP: rdata_o = hold_q[1];
      A_CTL: rdata_o = hold_q[2];
      default: begin
        rdata_o[ST_SEL]     = sel_q;
        rdata_o[ST_CNT_BSY] = busy_r[0];
        rdata_o[ST_CMP_BSY] = busy_r[1];
        rdata_o[ST_CTL_BSY] = busy_r[2];
      end
    endcase
  end

  // R3
  sync_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |-> (busy_r == '0));
  // R9
  sel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> (busy_r == '0));
endmodule

// File: tb/async_timer_bridge_test.sv
`timescale 1ns/1ps
module async_timer_bridge_test;
  import atb_pkg::*;

  logic clk = 0, rst_n = 0, tclk = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, wave, wr_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #35 tclk = ~tclk;

  async_timer_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wave_o(wave), .wr_err_o(wr_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(A_STAT, s);
      if (s[2:0] == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg read", v, 0);
    end
    chk("R1 outputs", {irq, wave, wr_err}, 0);
  endtask

  task automatic t_sync_rw();
    logic [7:0] v, a0, b0;
    wr(A_CTL, 8'h00);
    wr(A_CNT, 8'h5A); rd(A_CNT, v); chk("R3 counter write", v, 8'h5A);
    rd(A_STAT, v); chk("R3 busy stays 0", v, 0);
    wr(A_CMP, 8'h21); rd(A_CMP, v); chk("R3 compare write", v, 8'h21);
    wr(A_CTL, 8'h04); rd(A_CTL, v); chk("R3 control write", v, 8'h04);
    wr(A_CTL, 8'h01);
    rd(A_CNT, a0);
    repeat (10) @(negedge clk);
    rd(A_CNT, b0);
    chk("R3 count rate", 8'(b0 - a0), 10);
  endtask

  task automatic t_sync_match();
    int first = -1, second = -1, dbl = 0;
    logic prev = 0, w0, wflip = 0;
    wr(A_CTL, 8'h00); wr(A_CMP, 8'd10); wr(A_CNT, 8'd0);
    w0 = wave;
    wr(A_CTL, 8'h07);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq) begin
        if (first < 0) begin first = i; wflip = (wave != w0); end
        else if (second < 0) second = i;
      end
      if (irq && prev) dbl++;
      prev = irq;
    end
    chk("R8 clear-on-match period", second - first, 11);
    chk("R7 irq single cycle", dbl, 0);
    chk("R7 wave toggled", wflip, 1);
  endtask

  task automatic t_sync_wrap();
    int first = -1, second = -1;
    wr(A_CTL, 8'h00); wr(A_CMP, 8'd3); wr(A_CNT, 8'd0); wr(A_CTL, 8'h01);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (irq) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    chk("R8 wrap period", second - first, 256);
  endtask

  task automatic t_sync_collide();
    logic [7:0] v;
    bit found = 0;
    int n = 0;
    wr(A_CTL, 8'h00); wr(A_CMP, 8'd50); wr(A_CNT, 8'd40); wr(A_CTL, 8'h01);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rd(A_CNT, v);
      if (v == 8'd50) begin found = 1; break; end
    end
    chk("R10 reached compare", found, 1);
    wr_en = 1; addr = A_CNT; wdata = 8'h80;
    @(negedge clk); wr_en = 0;
    chk("R10 no irq on load", irq, 0);
    rd(A_CNT, v); chk("R10 load wins", v, 8'h80);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (irq) n++;
    end
    chk("R10 no late irq", n, 0);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_to_async();
    logic [7:0] v;
    wr(A_STAT, 8'h0F);
    rd(A_STAT, v); chk("R2 busy bits read-only", v, 8'h08);
    repeat (20) @(negedge clk);
    rd(A_CMP, v); chk("R9 compare cleared", v, 0);
    rd(A_CTL, v); chk("R9 control cleared", v, 0);
    rd(A_CNT, v); chk("R9 counter cleared", v, 0);
  endtask

  task automatic t_async_write();
    logic [7:0] v;
    wr(A_CMP, 8'h33);
    rd(A_STAT, v); chk("R4 compare busy", v, 8'h0A);
    rd(A_CMP, v); chk("R6 holding read", v, 8'h33);
    wr(A_CMP, 8'h44);
    chk("R5 error pulse", wr_err, 1);
    rd(A_CMP, v); chk("R5 write ignored", v, 8'h33);
    @(negedge clk);
    chk("R5 error one cycle", wr_err, 0);
    wait_idle();
    rd(A_STAT, v); chk("R4 busy cleared", v, 8'h08);
    wr(A_CTL, 8'h00); wait_idle();
    wr(A_CNT, 8'hF0); wait_idle();
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R6 live counter async", v, 8'hF0);
  endtask

  task automatic t_async_run();
    logic [7:0] v;
    int n = 0, dbl = 0, mx = 0;
    logic prev = 0;
    wr(A_CMP, 8'd5); wait_idle();
    wr(A_CNT, 8'd0); wait_idle();
    wr(A_CTL, 8'h07); wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq) n++;
      if (irq && prev) dbl++;
      prev = irq;
      rd(A_CNT, v);
      if (int'(v) > mx) mx = int'(v);
    end
    chk("R7 async irq seen", n > 5, 1);
    chk("R7 async irq single cycle", dbl, 0);
    chk("R8 async clear bound", (mx >= 1) && (mx <= 5), 1);
  endtask

  task automatic t_to_sync();
    logic [7:0] v;
    int n = 0;
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk("R9 status after switch", v, 0);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); chk("R9 counter cleared sync", v, 0);
    rd(A_CMP, v); chk("R9 compare cleared sync", v, 0);
    rd(A_CTL, v); chk("R9 control cleared sync", v, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (irq) n++;
    end
    chk("R9 stopped after switch", n, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sync_rw();
    t_sync_match();
    t_sync_wrap();
    t_sync_collide();
    t_to_async();
    t_async_write();
    t_async_run();
    t_to_sync();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule